// File: doc/BRIEF.md
# Paired-Counter PWM Generator

This block is a register-mapped peripheral that holds two identical counters, each of which can count up or down. Each counter can run alone as an interval timer that gives a one-cycle generate pulse at the end of every count cycle. When both counters are set up for pulse-width work, they act as a pair on one output. Counter 0 sets the period. Counter 1 sets how long the output stays high at the start of each period.

A count cycle is not a compare against one counter. It comes from the reload timing. A counter walks from its reload value to its terminal value, spends one more cycle reloading, and then starts again. So a cycle lasts two clocks more than the number of steps. Software writes the reload registers, pulses the load bit to preset the counters, and then starts both counters on the same edge with the enable-all bit. A high time equal to or longer than the period gives a constant low output, never a constant high one.

The counter width is the parameter `CNT_W`, which must be 8, 16 or 32, and the largest count is 2^CNT_W − 1. The bus is a plain 32-bit write strobe with word (4-byte) addressing and a combinational read.

Top module: `dual_timer_pwm`

## Requirements
- R1: After reset all six registers read 0 and `pwm_out`, `gen0_out` and `gen1_out` are low.
- R2: While a control register's load bit (bit 4) is set, its counter copies the reload register every cycle and does not count. This holds even when the run bit (bit 5) is set.
- R3: With run set, generate-enable (bit 2) and auto-reload (bit 3) set, the counter gives a one-cycle generate pulse every L+2 cycles in down mode (bit 0 = 1). In up mode (bit 0 = 0) the spacing is MAX−L+2 cycles. L is the reload value.
- R4: With auto-reload clear, a running counter gives one generate pulse, then halts at its terminal count.
- R5: Writing 1 to the enable-all bit (bit 8) of either control register sets the run bit of both counters on the same edge. The enable-all bit always reads back 0.
- R6: When the pair is valid, `pwm_out` is high for the first D cycles of every P-cycle period and low for the rest. P is counter 0's cycle length and D is counter 1's. The first period begins on the edge that makes the pair valid.
- R7: When D is equal to or greater than P, `pwm_out` stays low.
- R8: A reload-register write made while the pair runs takes effect only at the next period boundary. The period in progress keeps its old high time.
- R9: The pair is valid only when both control registers have capture-mode (bit 1) clear, pulse-width enable (bit 6), generate-enable, auto-reload and run set, and load clear, and counter 0 has cascade (bit 7) clear. Otherwise `pwm_out` is low. Writing 0 to a control register clears its run and pulse-width bits.
- R10: The word offsets are control 0 at 0x00, reload 0 at 0x04, count 0 at 0x08, control 1 at 0x0C, reload 1 at 0x10 and count 1 at 0x14. Count registers are read-only. Unaligned or unmapped writes are ignored, and unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| gen0_out | output | 1 | Counter 0 generate pulse |
| gen1_out | output | 1 | Counter 1 generate pulse |
| pwm_out | output | 1 | Pulse-width output |

## Verification
If the reload-pending flag or the halt flag is wrong, the generate spacing shifts by one or more cycles at the very next terminal count, so the pulse-spacing checks catch it within one cycle length. If the high-time latch is wrong, or counter 1 does not restart with counter 0, the measured high time or period is wrong in the first full period after the enable edge. The equal and over-long duty cases show whether the 0% rule holds. The mid-period reload write shows whether a new setting leaks into the period in progress.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Control register layout. Bit 0 is down, bit 7 is cascade.
    typedef struct packed {
        logic casc;
        logic pwm_en;
        logic run;
        logic load;
        logic auto_rl;
        logic gen_en;
        logic capture;
        logic down;
    } ctrl_t;

    localparam int CTRL_BITS = 8;
    localparam int EA_BIT    = 8;

    // Word indices of the register map.
    localparam int REG_CTRL0 = 0;
    localparam int REG_LOAD0 = 1;
    localparam int REG_CNT0  = 2;
    localparam int REG_CTRL1 = 3;
    localparam int REG_LOAD1 = 4;
    localparam int REG_CNT1  = 5;
    localparam int REGS_PER_TMR = 3;

    // One counter is set up for pulse-width pairing.
    function automatic logic tmr_ready(input ctrl_t c);
        return !c.capture && c.pwm_en && c.gen_en && c.auto_rl && c.run && !c.load;
    endfunction

    // The whole pair is valid.
    function automatic logic pair_ready(input ctrl_t c0, input ctrl_t c1);
        return tmr_ready(c0) && tmr_ready(c1) && !c0.casc;
    endfunction

    // Cycle length minus two, in counts.
    function automatic logic [31:0] span32(input logic down, input logic [31:0] ld,
                                           input logic [31:0] mx);
        return down ? ld : (mx - ld);
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile import pwm_pkg::*; #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [CNT_W-1:0]  cnt_in [2],
    output logic [31:0]       rdata,
    output ctrl_t             ctrl_q [2],
    output ctrl_t             ctrl_d [2],
    output logic [CNT_W-1:0]  load_q [2]
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             aligned;
    logic             ea_hit;
    logic             hit_ctrl [2];
    logic             hit_load [2];

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        for (int t = 0; t < 2; t++) begin
            hit_ctrl[t] = wr_en && aligned && (int'(widx) == t*REGS_PER_TMR + REG_CTRL0);
            hit_load[t] = wr_en && aligned && (int'(widx) == t*REGS_PER_TMR + REG_LOAD0);
        end
    end

    assign ea_hit = (hit_ctrl[0] || hit_ctrl[1]) && wdata[EA_BIT];

    // Next-state control values. The enable-all bit is never stored.
    always_comb begin
        for (int t = 0; t < 2; t++) begin
            ctrl_d[t] = ctrl_q[t];
            if (hit_ctrl[t])
                ctrl_d[t] = ctrl_t'(wdata[CTRL_BITS-1:0]);
            if (ea_hit)
                ctrl_d[t].run = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < 2; t++) begin
                ctrl_q[t] <= '0;
                load_q[t] <= '0;
            end
        end else begin
            for (int t = 0; t < 2; t++) begin
                ctrl_q[t] <= ctrl_d[t];
                if (hit_load[t])
                    load_q[t] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (int'(widx))
                REG_CTRL0: rdata = 32'(ctrl_q[0]);
                REG_LOAD0: rdata = 32'(load_q[0]);
                REG_CNT0:  rdata = 32'(cnt_in[0]);
                REG_CTRL1: rdata = 32'(ctrl_q[1]);
                REG_LOAD1: rdata = 32'(load_q[1]);
                REG_CNT1:  rdata = 32'(cnt_in[1]);
                default:   rdata = '0;
            endcase
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{wdata[31:EA_BIT+1]};

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter import pwm_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] load_val,
    input  logic             sync_reload,
    input  logic             hold_after,
    output logic [CNT_W-1:0] cnt,
    output logic             gen
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             rl_q;    // reload cycle, the last cycle of a count cycle
    logic             done_q;  // halted at terminal, waiting for a restart
    logic [CNT_W-1:0] term;

    assign term = ctrl.down ? '0 : CNT_MAX;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rl_q   <= 1'b0;
            done_q <= 1'b0;
        end else if (ctrl.load) begin
            cnt    <= load_val;
            rl_q   <= 1'b0;
            done_q <= 1'b0;
        end else if (!ctrl.run) begin
            rl_q   <= 1'b0;
            done_q <= 1'b0;
        end else if (sync_reload) begin
            cnt    <= load_val;
            rl_q   <= 1'b0;
            done_q <= 1'b0;
        end else if (rl_q) begin
            rl_q <= 1'b0;
            if (ctrl.auto_rl && !hold_after)
                cnt <= load_val;
            else
                done_q <= 1'b1;
        end else if (!done_q) begin
            if (cnt == term)
                rl_q <= 1'b1;
            else if (ctrl.down)
                cnt <= cnt - 1'b1;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign gen = rl_q && ctrl.gen_en && ctrl.run;

    logic unused_ctrl;
    assign unused_ctrl = ^{ctrl.casc, ctrl.pwm_en, ctrl.capture};

endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper (
    input  logic clk,
    input  logic rst,
    input  logic valid_q,
    input  logic valid_d,
    input  logic gen_period,
    input  logic gen_duty,
    input  logic duty_fits,
    output logic pwm
);
    // Clear beats set. A start or a period boundary sets the output
    // only when the high time is strictly shorter than the period.
    always_ff @(posedge clk) begin
        if (rst)
            pwm <= 1'b0;
        else if (!valid_d)
            pwm <= 1'b0;
        else if (!valid_q)
            pwm <= duty_fits;
        else if (gen_duty)
            pwm <= 1'b0;
        else if (gen_period)
            pwm <= duty_fits;
    end

endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm import pwm_pkg::*; #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              gen0_out,
    output logic              gen1_out,
    output logic              pwm_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ctrl_t            ctrl_q [2];
    ctrl_t            ctrl_d [2];
    logic [CNT_W-1:0] load_q [2];
    logic [CNT_W-1:0] cnt    [2];
    logic             gen    [2];
    logic             sync   [2];
    logic             hold   [2];
    logic             valid_q;
    logic             valid_d;
    logic             duty_fits;

    pwm_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cnt_in (cnt),
        .rdata  (bus_rdata),
        .ctrl_q (ctrl_q),
        .ctrl_d (ctrl_d),
        .load_q (load_q)
    );

    assign valid_q = pair_ready(ctrl_q[0], ctrl_q[1]);
    assign valid_d = pair_ready(ctrl_d[0], ctrl_d[1]);

    assign duty_fits = span32(ctrl_q[1].down, 32'(load_q[1]), 32'(CNT_MAX))
                     < span32(ctrl_q[0].down, 32'(load_q[0]), 32'(CNT_MAX));

    // Counter 0 runs freely. When paired, counter 1 holds after its pulse
    // and restarts with counter 0.
    assign sync[0] = 1'b0;
    assign hold[0] = 1'b0;
    assign sync[1] = valid_q && gen[0];
    assign hold[1] = valid_q;

    for (genvar i = 0; i < 2; i++) begin : g_tmr
        pwm_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk         (clk),
            .rst         (rst),
            .ctrl        (ctrl_q[i]),
            .load_val    (load_q[i]),
            .sync_reload (sync[i]),
            .hold_after  (hold[i]),
            .cnt         (cnt[i]),
            .gen         (gen[i])
        );
    end

    pwm_shaper u_shape (
        .clk        (clk),
        .rst        (rst),
        .valid_q    (valid_q),
        .valid_d    (valid_d),
        .gen_period (gen[0]),
        .gen_duty   (gen[1]),
        .duty_fits  (duty_fits),
        .pwm        (pwm_out)
    );

    assign gen0_out = gen[0];
    assign gen1_out = gen[1];

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             pwm_out,
    input logic             gen0,
    input logic             gen1,
    input logic             valid_q,
    input logic             valid_d,
    input logic             ld0_held,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] load0
);
    // R9: output low whenever the pair is not valid
    a_r9_low_when_invalid: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> !pwm_out);

    // R3: generate pulses last exactly one cycle
    a_r3_gen0_one_cycle: assert property (@(posedge clk) disable iff (rst)
        gen0 |=> !gen0);
    a_r3_gen1_one_cycle: assert property (@(posedge clk) disable iff (rst)
        gen1 |=> !gen1);

    // R2: a held load bit copies the reload register into the counter
    a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
        ld0_held |=> (cnt0 == $past(load0)));

    // R6: the duty pulse ends the high phase on the next cycle
    a_r6_duty_ends_high: assert property (@(posedge clk) disable iff (rst)
        (valid_q && valid_d && gen1) |=> !pwm_out);

endmodule

bind dual_timer_pwm pwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwm_out  (pwm_out),
    .gen0     (gen[0]),
    .gen1     (gen[1]),
    .valid_q  (valid_q),
    .valid_d  (valid_d),
    .ld0_held (ctrl_q[0].load),
    .cnt0     (cnt[0]),
    .load0    (load_q[0])
);

// File: tb/sim_dual_timer_pwm.sv
`timescale 1ns/1ps
module sim_dual_timer_pwm;
    localparam int W      = 16;
    localparam int AW     = 5;
    localparam int MAXV   = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          gen0_out, gen1_out, pwm_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dual_timer_pwm #(.CNT_W(W), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gen0_out(gen0_out), .gen1_out(gen1_out), .pwm_out(pwm_out)
    );

    typedef struct { int hi; int per; string req; } item_t;
    item_t exp_q[$];
    item_t meas_q[$];
    logic  mon_en = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int expv, input string req);
        bus_addr = AW'(a);
        #1;
        check(bus_rdata == 32'(expv), req, int'(bus_rdata), expv);
    endtask

    // Monitor: measures every rise-to-rise period of pwm_out.
    initial begin
        int cyc = 0, start = 0, hi = 0;
        bit have = 0;
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (pwm_out && !prev) begin
                if (have && mon_en) meas_q.push_back('{hi, cyc - start, ""});
                have = 1; start = cyc; hi = 0;
            end
            if (pwm_out) hi++;
            prev = pwm_out;
        end
    end

    // Scoreboard compare.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0 && meas_q.size() > 0) begin
                item_t e, m;
                e = exp_q.pop_front();
                m = meas_q.pop_front();
                check(m.hi == e.hi, {e.req, " high time"}, m.hi, e.hi);
                check(m.per == e.per, {e.req, " period"}, m.per, e.per);
            end
        end
    end

    task automatic expect_pwm(input int hi, input int per, input string req);
        exp_q.push_back('{hi, per, req});
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() > 0 && n < 3000) begin @(negedge clk); n++; end
        check(exp_q.size() == 0, {req, " periods seen"}, exp_q.size(), 0);
        mon_en = 1'b0;
        exp_q.delete();
        meas_q.delete();
    endtask

    // Starts the pair: down bit given per counter, loads already chosen.
    task automatic start_pair(input int l0, input int l1, input int down);
        wr(32'h00, 0); wr(32'h0C, 0);
        wr(32'h04, l0); wr(32'h10, l1);
        wr(32'h00, 32'h10 | down); wr(32'h0C, 32'h10 | down);
        wr(32'h00, 32'h4C | down); wr(32'h0C, 32'h14C | down);
    endtask

    task automatic gen_spacing(output int n);
        int k = 0;
        n = -1;
        while (!gen0_out && k < 2000) begin @(negedge clk); k++; end
        if (!gen0_out) return;
        @(negedge clk);
        check(!gen0_out, "R3 pulse width", int'(gen0_out), 0);
        n = 1;
        while (!gen0_out && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic count_high(input int cycles, output int h);
        h = 0;
        for (int i = 0; i < cycles; i++) begin @(negedge clk); if (pwm_out) h++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) rd(a * 4, 0, "R1");
        check(!pwm_out && !gen0_out && !gen1_out, "R1 outputs", int'(pwm_out), 0);

        // R10 map: count registers read-only, unaligned / unmapped ignored
        wr(32'h04, 77);
        wr(32'h08, 32'h1234);
        rd(32'h08, 0, "R10 count read-only");
        wr(32'h05, 99);
        rd(32'h04, 77, "R10 unaligned write ignored");
        wr(32'h18, 55);
        rd(32'h18, 0, "R10 unmapped read");
        wr(32'h10, 33);
        rd(32'h10, 33, "R10 reload1 offset");

        // R2 load bit holds the counter even with run set
        wr(32'h04, 100);
        wr(32'h00, 32'h30);
        repeat (3) @(negedge clk);
        rd(32'h08, 100, "R2 held by load");
        wr(32'h00, 32'h21);
        rd(32'h08, 100, "R2 released");
        @(negedge clk);
        rd(32'h08, 99, "R2 counts after release");

        // R3 down-mode spacing L+2
        wr(32'h00, 0);
        wr(32'h04, 5); wr(32'h00, 32'h11); wr(32'h00, 32'h2D);
        gen_spacing(n);
        check(n == 7, "R3 down spacing", n, 7);
        // R3 up-mode spacing MAX-L+2
        wr(32'h00, 0);
        wr(32'h04, MAXV - 5); wr(32'h00, 32'h10); wr(32'h00, 32'h2C);
        gen_spacing(n);
        check(n == 7, "R3 up spacing", n, 7);

        // R4 no auto-reload: one pulse, then halt
        wr(32'h00, 0);
        wr(32'h04, 3); wr(32'h00, 32'h11); wr(32'h00, 32'h25);
        h = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (gen0_out) h++; end
        check(h == 1, "R4 single pulse", h, 1);
        rd(32'h08, 0, "R4 halted at terminal");

        // R5 enable-all starts both counters on one edge
        wr(32'h00, 0);
        wr(32'h04, 50); wr(32'h10, 30);
        wr(32'h00, 32'h11); wr(32'h0C, 32'h11);
        wr(32'h00, 32'h01); wr(32'h0C, 32'h101);
        rd(32'h08, 50, "R5 cnt0 start");
        @(negedge clk);
        rd(32'h14, 29, "R5 cnt1 running");
        @(negedge clk);
        rd(32'h08, 48, "R5 cnt0 running");
        rd(32'h00, 32'h21, "R5 run set, enable-all reads 0");
        rd(32'h0C, 32'h21, "R5 run set in ctrl1");

        // R6 down mode, P=10, D=4; first period starts on the enable edge
        start_pair(8, 2, 1);
        check(pwm_out == 1'b1, "R6 first period high", int'(pwm_out), 1);
        mon_en = 1'b1;
        expect_pwm(4, 10, "R6 P10 D4");
        expect_pwm(4, 10, "R6 P10 D4");
        drain("R6");

        // R8 reload write mid-period applies at next boundary
        start_pair(8, 2, 1);
        repeat (3) @(negedge clk);
        while (pwm_out) @(negedge clk);
        while (!pwm_out) @(negedge clk);
        wr(32'h10, 5);
        mon_en = 1'b1;
        expect_pwm(4, 10, "R8 current period");
        expect_pwm(7, 10, "R8 next period");
        drain("R8");

        // R6 up mode, P=20, D=15
        start_pair(MAXV - 18, MAXV - 13, 0);
        mon_en = 1'b1;
        expect_pwm(15, 20, "R6 up P20 D15");
        expect_pwm(15, 20, "R6 up P20 D15");
        drain("R6 up");

        // R6 minimum, P=3, D=2
        start_pair(1, 0, 1);
        mon_en = 1'b1;
        expect_pwm(2, 3, "R6 P3 D2");
        expect_pwm(2, 3, "R6 P3 D2");
        drain("R6 min");

        // R7 equal and longer high time give 0%
        start_pair(6, 6, 1);
        count_high(40, h);
        check(h == 0, "R7 D equal P", h, 0);
        start_pair(4, 7, 1);
        count_high(40, h);
        check(h == 0, "R7 D above P", h, 0);

        // R9 cascade on counter 0 invalidates; writing 0 clears run
        start_pair(8, 2, 1);
        wr(32'h00, 32'hED);
        count_high(40, h);
        check(h == 0, "R9 cascade forces low", h, 0);
        start_pair(8, 2, 1);
        wr(32'h0C, 32'h49);
        count_high(40, h);
        check(h == 0, "R9 gen-enable clear forces low", h, 0);
        start_pair(8, 2, 1);
        wr(32'h00, 0);
        count_high(40, h);
        check(h == 0, "R9 disabled low", h, 0);
        rd(32'h00, 0, "R9 zero write clears run and pwm");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule